// File: doc/BRIEF.md
# Multi-Output Response Compactor

This block folds the per-pattern responses of a logic block with K outputs into an N-stage signature. The signature is the remainder of a response polynomial divided by one characteristic polynomial, which is shared by three run-time modes. Serial-select mode compacts one chosen output per pass, so K passes cover every output. Parity mode XOR-reduces all K outputs to one bit per pattern and divides that bit stream. Parallel mode folds up to N outputs into the register on every pattern, as N time-shifted serial analyzers would.

The signature starts from an all-zero seed on synchronous reset and advances only on cycles that carry a valid response. When the pattern set is finished, the test controller pulses `done` with the expected signature on `golden`. One cycle later the block reports a pass/fail verdict. If K exceeds N, the parallel mode accepts only the low N outputs, and the serial-select or parity modes should be used to observe the rest.

Top module: `resp_compactor`

## Requirements
- R1: A synchronous reset (`rst` high) clears the signature to zero and holds `check_vld` and `pass` low on the following cycle.
- R2: The signature changes only on a clock edge where `resp_valid` is high. When `resp_valid` is low it holds its value, whatever `resp`, `sel` or `mode` do.
- R3: A serial update multiplies the signature by X, reduces it modulo P(X) and adds the input bit as the X^0 coefficient. The first bit applied therefore carries the highest weight. P(X) is X^N plus the low terms given by the parameter `POLY`, and the default is X^4 + X + 1 (`POLY` = 4'b0011).
- R4: With `mode` = 2'b00 (serial-select), the serial bit is `resp[sel]`. A `sel` value of K or above gives a serial bit of 0.
- R5: With `mode` = 2'b01 (parity), the serial bit is the XOR of all K response bits. Patterns whose parities are 1,0,0,0,1, applied from a zero seed, leave the signature 4'b0010.
- R6: With `mode` = 2'b10 (parallel), the next signature is the signature shifted with feedback, XORed with `resp[N-1:0]`, where response bit i enters stage i. Five patterns with `resp[3:0]` = 1000, 0110, 0101, 0110, 1110 give 4'b1011 from a zero seed.
- R7: In parallel mode with K > N, response bits N to K-1 have no effect on the signature.
- R8: `mode` = 2'b11 is reserved. A valid response in this mode leaves the signature unchanged.
- R9: A `done` pulse raises `check_vld` for exactly the next cycle. On that cycle `pass` is 1 exactly when the signature held in the `done` cycle equals `golden`.
- R10: `pass` is low on every cycle where `check_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, loads the zero seed |
| mode | input | 2 | 00 serial-select, 01 parity, 10 parallel, 11 reserved |
| resp | input | K | Response bits of one pattern |
| resp_valid | input | 1 | Strobe: fold `resp` this cycle |
| sel | input | SELW | Output index for serial-select mode |
| golden | input | N | Expected signature |
| done | input | 1 | End of test, request a verdict |
| signature | output | N | Current signature |
| check_vld | output | 1 | Verdict valid, one cycle after `done` |
| pass | output | 1 | Signature matched `golden` |

## Verification
The bench feeds the parity and parallel worked examples and expects 4'b0010 and 4'b1011. A design with the wrong bit order, the wrong feedback taps or the wrong stage mapping lands on a different remainder. It drives parallel mode with the bits above N set, both ways. A design that folds those bits in, or that wraps them onto low stages, gives a signature that depends on them. It also drives an out-of-range `sel`, the reserved mode and invalid cycles with busy inputs. In each of these cases a faulty design would shift stray data into the register. A behavioural polynomial model is compared against the design on every clock, and a matching and a mismatching `golden` catch an inverted or late verdict.

// File: rtl/resp_compactor_pkg.sv
package resp_compactor_pkg;
   typedef enum logic [1:0] {
      CMP_SERIAL_SEL = 2'b00,
      CMP_PARITY     = 2'b01,
      CMP_PARALLEL   = 2'b10,
      CMP_RESERVED   = 2'b11
   } cmp_mode_e;
endpackage

// File: rtl/cmp_input_fold.sv
module cmp_input_fold #(
   parameter int K    = 6,
   parameter int N    = 4,
   parameter int SELW = 3
) (
   input  logic [K-1:0]    resp,
   input  logic [SELW-1:0] sel,
   input  logic            use_parity,
   output logic            ser_bit,
   output logic [N-1:0]    par_vec
);
   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < K; i++) begin
         if (sel == SELW'(i)) picked = resp[i];
      end
   end

   assign ser_bit = use_parity ? (^resp) : picked;

   generate
      if (K >= N) begin : g_trunc
         assign par_vec = resp[N-1:0];
      end else begin : g_pad
         assign par_vec = {{(N-K){1'b0}}, resp};
      end
   endgenerate
endmodule

// File: rtl/cmp_sig_reg.sv
module cmp_sig_reg #(
   parameter int         N    = 4,
   parameter logic [N-1:0] POLY = 4'b0011
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         serial,
   input  logic         ser_bit,
   input  logic [N-1:0] par_vec,
   output logic [N-1:0] sig
);
   logic [N-1:0] shifted;
   logic [N-1:0] inject;

   always_comb begin
      shifted = {sig[N-2:0], 1'b0} ^ (sig[N-1] ? POLY : '0);
      inject  = serial ? {{(N-1){1'b0}}, ser_bit} : par_vec;
   end

   always_ff @(posedge clk) begin
      if (rst)     sig <= '0;
      else if (en) sig <= shifted ^ inject;
   end

   // R1
   zero_seed_chk: assert property (@(posedge clk) rst |=> (sig == '0));
   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(sig));
endmodule

// File: rtl/cmp_verdict.sv
module cmp_verdict #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         done,
   input  logic [N-1:0] sig,
   input  logic [N-1:0] golden,
   output logic         check_vld,
   output logic         pass
);
   always_ff @(posedge clk) begin
      if (rst) begin
         check_vld <= 1'b0;
         pass      <= 1'b0;
      end else begin
         check_vld <= done;
         pass      <= done && (sig == golden);
      end
   end

   // R9
   verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> check_vld);
   // R9
   verdict_value_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (pass == ($past(sig) == $past(golden))));
   // R10
   pass_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !check_vld |-> !pass);
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
   import resp_compactor_pkg::*;
#(
   parameter int           K    = 6,
   parameter int           N    = 4,
   parameter logic [N-1:0] POLY = 4'b0011,
   localparam int          SELW = (K > 1) ? $clog2(K) + 1 : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      mode,
   input  logic [K-1:0]    resp,
   input  logic            resp_valid,
   input  logic [SELW-1:0] sel,
   input  logic [N-1:0]    golden,
   input  logic            done,
   output logic [N-1:0]    signature,
   output logic            check_vld,
   output logic            pass
);
   cmp_mode_e    mode_e;
   logic         ser_bit;
   logic [N-1:0] par_vec;
   logic         serial;
   logic         en;

   assign mode_e = cmp_mode_e'(mode);
   assign serial = (mode_e == CMP_SERIAL_SEL) || (mode_e == CMP_PARITY);
   assign en     = resp_valid && (mode_e != CMP_RESERVED);

   cmp_input_fold #(.K(K), .N(N), .SELW(SELW)) u_fold (
      .resp       (resp),
      .sel        (sel),
      .use_parity (mode_e == CMP_PARITY),
      .ser_bit    (ser_bit),
      .par_vec    (par_vec)
   );

   cmp_sig_reg #(.N(N), .POLY(POLY)) u_sig (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .serial  (serial),
      .ser_bit (ser_bit),
      .par_vec (par_vec),
      .sig     (signature)
   );

   cmp_verdict #(.N(N)) u_verdict (
      .clk       (clk),
      .rst       (rst),
      .done      (done),
      .sig       (signature),
      .golden    (golden),
      .check_vld (check_vld),
      .pass      (pass)
   );

   // R8
   reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && mode == 2'b11) |=> $stable(signature));
   // R2
   valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !resp_valid |=> $stable(signature));
endmodule

// File: tb/tb_resp_compactor.sv
module tb_resp_compactor;
   localparam int K = 6;
   localparam int N = 4;
   localparam int SELW = $clog2(K) + 1;
   localparam int POLYI = 3;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [1:0]      mode = 2'b00;
   logic [K-1:0]    resp = '0;
   logic            resp_valid = 1'b0;
   logic [SELW-1:0] sel = '0;
   logic [N-1:0]    golden = '0;
   logic            done = 1'b0;
   logic [N-1:0]    signature;
   logic            check_vld;
   logic            pass;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int m_sig = 0;
   int m_vld = 0;
   int m_pass = 0;
   bit live = 0;

   resp_compactor #(.K(K), .N(N)) dut (
      .clk(clk), .rst(rst), .mode(mode), .resp(resp), .resp_valid(resp_valid),
      .sel(sel), .golden(golden), .done(done), .signature(signature),
      .check_vld(check_vld), .pass(pass));

   always #5 clk = ~clk;

   function automatic int reduce_x(int s);
      int t = s << 1;
      if (t[N]) t = t ^ ((1 << N) | POLYI);
      return t;
   endfunction

   function automatic int model_step(int s, int md, int r, int sl);
      int b = 0;
      case (md)
         0: b = (sl < K) ? ((r >> sl) & 1) : 0;
         1: for (int i = 0; i < K; i++) b = b ^ ((r >> i) & 1);
         default: b = 0;
      endcase
      if (md == 3) return s;
      if (md == 2) return reduce_x(s) ^ (r & ((1 << N) - 1));
      return reduce_x(s) ^ b;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_sig = 0; m_vld = 0; m_pass = 0;
      end else begin
         m_vld  = done ? 1 : 0;
         m_pass = (done && (m_sig == int'(golden))) ? 1 : 0;
         if (resp_valid) m_sig = model_step(m_sig, int'(mode), int'(resp), int'(sel));
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R2 R3: per-cycle comparison against the model
   always @(negedge clk) begin
      if (live) begin
         check("R2 model signature", int'(signature), m_sig);
         check("R9 model verdict", int'(check_vld), m_vld);
         check("R10 model pass", int'(pass), m_pass);
      end
   end

   task automatic apply(int md, int r, int sl, bit v);
      mode = md[1:0]; resp = r[K-1:0]; sel = sl[SELW-1:0]; resp_valid = v;
      @(negedge clk);
      resp_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic verdict(int g);
      golden = g[N-1:0]; done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   int snap;

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      live = 1;
      check("R1 reset signature", int'(signature), 0);
      check("R1 reset check_vld", int'(check_vld), 0);
      check("R1 reset pass", int'(pass), 0);

      // R5 parity example: parities 1,0,0,0,1
      apply(1, 6'b000001, 0, 1);
      apply(1, 6'b000011, 0, 1);
      apply(1, 6'b110000, 0, 1);
      apply(1, 6'b000000, 0, 1);
      apply(1, 6'b111000, 0, 1);
      check("R5 parity remainder", int'(signature), 4'b0010);
      verdict(4'b0010);
      check("R9 verdict valid", int'(check_vld), 1);
      check("R9 matching pass", int'(pass), 1);
      @(negedge clk);
      check("R9 one-cycle verdict", int'(check_vld), 0);
      check("R10 pass low", int'(pass), 0);

      // R6 R7 parallel example, upper bits set
      do_reset();
      check("R1 reset after use", int'(signature), 0);
      apply(2, 6'b101000, 0, 1);
      apply(2, 6'b010110, 0, 1);
      apply(2, 6'b110101, 0, 1);
      apply(2, 6'b100110, 0, 1);
      apply(2, 6'b011110, 0, 1);
      check("R6 parallel remainder", int'(signature), 4'b1011);
      verdict(4'b0000);
      check("R9 mismatch verdict valid", int'(check_vld), 1);
      check("R9 mismatch pass", int'(pass), 0);
      do_reset();
      apply(2, 6'b001000, 0, 1);
      apply(2, 6'b000110, 0, 1);
      apply(2, 6'b000101, 0, 1);
      apply(2, 6'b000110, 0, 1);
      apply(2, 6'b001110, 0, 1);
      check("R7 upper bits ignored", int'(signature), 4'b1011);

      // R4 serial-select, in range and out of range
      do_reset();
      apply(0, 6'b000100, 2, 1);
      apply(0, 6'b111011, 2, 1);
      apply(0, 6'b000100, 2, 1);
      check("R4 select output 2", int'(signature), 4'b0101);
      do_reset();
      for (int i = 0; i < 4; i++) apply(0, 6'b111111, 7, 1);
      check("R4 out-of-range select", int'(signature), 0);
      apply(0, 6'b111111, 6, 1);
      check("R4 select equal to K", int'(signature), 0);

      // R8 reserved mode and R2 invalid cycles
      apply(1, 6'b000001, 0, 1);
      snap = int'(signature);
      apply(3, 6'b111111, 1, 1);
      apply(3, 6'b010101, 0, 1);
      check("R8 reserved mode hold", int'(signature), snap);
      apply(2, 6'b111111, 3, 0);
      apply(1, 6'b000001, 0, 0);
      check("R2 invalid hold", int'(signature), snap);

      // R3 mixed traffic against the model
      for (int i = 0; i < 300; i++) begin
         apply($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 7),
               1'($urandom_range(0, 1)));
         if ((i % 37) == 0) verdict($urandom_range(0, 15));
      end
      live = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end
endmodule